// File: doc/BRIEF.md
# Multiplexed bidirectional bus latch

This block couples one A-side bus with two B-side buses, bank 1 and bank 2, so that a single port can interleave traffic to and from two wider-spread buses. Each A-to-B path owns a level-sensitive storage latch, and each bank's B-to-A path owns one as well, giving four latches with four independent latch enables. A bank-select input decides which bank's B-to-A latch is presented on the A side.

Every port pin is modelled as a data-out plus drive-enable pair rather than a real tri-state pin. Three active-low output enables, one per port, gate those drive enables; the two B-side enables give bank control in the A-to-B direction, so A data may go to bank 1 only, bank 2 only, or both. Storage needs no clock; an active-low clear empties all four latches for deterministic start-up.

Top module: `mux_bus_latch`

## Requirements
- R1: While `rst_n` is 0, all four latches hold zero, whatever their enables and inputs; after `rst_n` returns to 1 with enables low they stay zero.
- R2: While `le_a2b1` (or `le_a2b2`) is 1 and `rst_n` is 1, the corresponding bank latch is transparent: `b1_out` (or `b2_out`) equals `a_in` when that bank's output is enabled.
- R3: When an A-to-B latch enable falls from 1 to 0, the A value present is captured and kept on that bank's output while `a_in` changes afterward.
- R4: Each B-to-A latch is transparent while `le_b1a` / `le_b2a` is 1 and holds the value captured at the falling edge of that enable while its B input changes.
- R5: `sel_bank` = 0 routes the bank-1 B-to-A latch to `a_out`; `sel_bank` = 1 routes the bank-2 latch.
- R6: Output enables are active low: `a_oe` = !`oe_a_n`, `b1_oe` = !`oe_b1_n`, `b2_oe` = !`oe_b2_n`, independently of each other.
- R7: Deasserting an output enable leaves the latch contents unchanged; on re-enable the port again shows the stored value.
- R8: Loading or holding one latch never changes the contents of any of the other three.
- R9: With the default `IDLE_ZERO` = 1, a port whose drive enable is 0 presents all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low clear of all four latches |
| sel_bank | input | 1 | 0 routes bank 1, 1 routes bank 2 to the A side |
| le_a2b1 | input | 1 | Latch enable, A to bank 1 |
| le_a2b2 | input | 1 | Latch enable, A to bank 2 |
| le_b1a | input | 1 | Latch enable, bank 1 to A |
| le_b2a | input | 1 | Latch enable, bank 2 to A |
| oe_a_n | input | 1 | Active-low output enable of the A side |
| oe_b1_n | input | 1 | Active-low output enable of bank 1 |
| oe_b2_n | input | 1 | Active-low output enable of bank 2 |
| a_in | input | WIDTH | Data received on the A side |
| a_out | output | WIDTH | Data driven onto the A side |
| a_oe | output | 1 | Drive enable of the A side |
| b1_in | input | WIDTH | Data received on bank 1 |
| b1_out | output | WIDTH | Data driven onto bank 1 |
| b1_oe | output | 1 | Drive enable of bank 1 |
| b2_in | input | WIDTH | Data received on bank 2 |
| b2_out | output | WIDTH | Data driven onto bank 2 |
| b2_oe | output | 1 | Drive enable of bank 2 |

## Verification
Every result of this block is due in the same cycle as its stimulus: transparency, bank routing and enable gating are pure combinational paths, and a capture takes effect at the falling edge of a latch enable with no clock involved. The bench therefore changes inputs just after a falling clock edge and samples outputs a quarter period later, once all paths have settled and well clear of the next rising edge. Hold checks change the captured input only after the enable has already fallen and been sampled, so a held value is never confused with a transparent one.

// File: rtl/mbl_pkg.sv
package mbl_pkg;
   localparam int NBANK = 2;
   typedef enum logic {
      BANK_ONE = 1'b0,
      BANK_TWO = 1'b1
   } bank_e;
endpackage

// File: rtl/mbl_latch.sv
module mbl_latch #(
   parameter int WIDTH = 12
) (
   input  logic             rst_n,
   input  logic             le,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 1) begin : g_bad_width
      $error("mbl_latch: WIDTH must be at least 1");
   end

   always_latch begin
      if (!rst_n)
         q = '0;
      else if (le)
         q = d;
   end

   // Clear dominates the enable.
   always_comb begin
      if (!rst_n)
         assert_clear_R1 : assert (q == '0);
   end

   // An open latch presents its input.
   always_comb begin
      if (rst_n && le)
         assert_transparent_R2 : assert (q == d);
   end
endmodule

// File: rtl/mbl_drv.sv
module mbl_drv #(
   parameter int WIDTH     = 12,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic             oe_n,
   input  logic [WIDTH-1:0] data,
   output logic [WIDTH-1:0] dout,
   output logic             den
);
   assign den = ~oe_n;

   if (IDLE_ZERO) begin : g_idle_zero
      assign dout = den ? data : '0;
      always_comb begin
         if (!den)
            assert_idle_zero_R9 : assert (dout == '0);
      end
   end else begin : g_idle_pass
      assign dout = data;
   end
endmodule

// File: rtl/mux_bus_latch.sv
module mux_bus_latch #(
   parameter int WIDTH     = 12,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic             rst_n,
   input  logic             sel_bank,
   input  logic             le_a2b1,
   input  logic             le_a2b2,
   input  logic             le_b1a,
   input  logic             le_b2a,
   input  logic             oe_a_n,
   input  logic             oe_b1_n,
   input  logic             oe_b2_n,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   input  logic [WIDTH-1:0] b1_in,
   output logic [WIDTH-1:0] b1_out,
   output logic             b1_oe,
   input  logic [WIDTH-1:0] b2_in,
   output logic [WIDTH-1:0] b2_out,
   output logic             b2_oe
);
   import mbl_pkg::*;

   if (WIDTH < 1) begin : g_bad_width
      $error("mux_bus_latch: WIDTH must be at least 1");
   end

   logic [NBANK-1:0]            le_down, le_up, oe_b_n, b_oe;
   logic [NBANK-1:0][WIDTH-1:0] b_in, q_down, q_up, b_out;
   logic [WIDTH-1:0]            a_sel;
   bank_e                       bank;

   assign le_down = {le_a2b2, le_a2b1};
   assign le_up   = {le_b2a,  le_b1a};
   assign oe_b_n  = {oe_b2_n, oe_b1_n};
   assign b_in    = {b2_in,   b1_in};

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      mbl_latch #(.WIDTH(WIDTH)) u_down (
         .rst_n (rst_n),
         .le    (le_down[g]),
         .d     (a_in),
         .q     (q_down[g])
      );
      mbl_latch #(.WIDTH(WIDTH)) u_up (
         .rst_n (rst_n),
         .le    (le_up[g]),
         .d     (b_in[g]),
         .q     (q_up[g])
      );
      mbl_drv #(.WIDTH(WIDTH), .IDLE_ZERO(IDLE_ZERO)) u_drv (
         .oe_n  (oe_b_n[g]),
         .data  (q_down[g]),
         .dout  (b_out[g]),
         .den   (b_oe[g])
      );
   end

   assign bank  = bank_e'(sel_bank);
   assign a_sel = (bank == BANK_TWO) ? q_up[1] : q_up[0];

   mbl_drv #(.WIDTH(WIDTH), .IDLE_ZERO(IDLE_ZERO)) u_drv_a (
      .oe_n  (oe_a_n),
      .data  (a_sel),
      .dout  (a_out),
      .den   (a_oe)
   );

   assign b1_out = b_out[0];
   assign b2_out = b_out[1];
   assign b1_oe  = b_oe[0];
   assign b2_oe  = b_oe[1];

   // Enabled A side shows the latch of the selected bank.
   always_comb begin
      if (a_oe && !sel_bank)
         assert_route_bank1_R5 : assert (a_out == q_up[0]);
      if (a_oe && sel_bank)
         assert_route_bank2_R5 : assert (a_out == q_up[1]);
   end

   // Each drive enable tracks only its own active-low enable.
   always_comb begin
      assert_oe_polarity_R6 : assert ({a_oe, b2_oe, b1_oe} == ~{oe_a_n, oe_b2_n, oe_b1_n});
   end

   // Enabled bank ports show their own stored value.
   always_comb begin
      if (b1_oe)
         assert_bank1_drive_R7 : assert (b1_out == q_down[0]);
      if (b2_oe)
         assert_bank2_drive_R7 : assert (b2_out == q_down[1]);
   end
endmodule

// File: tb/mux_bus_latch_test.sv
module mux_bus_latch_test;
   localparam int W = 12;

   logic         clk = 1'b0;
   logic         rst_n, sel_bank;
   logic         le_a2b1, le_a2b2, le_b1a, le_b2a;
   logic         oe_a_n, oe_b1_n, oe_b2_n;
   logic [W-1:0] a_in, b1_in, b2_in;
   logic [W-1:0] a_out, b1_out, b2_out;
   logic         a_oe, b1_oe, b2_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // Bench model of the four latches.
   logic [W-1:0] m_d1, m_d2, m_u1, m_u2;

   always #10 clk = ~clk;

   mux_bus_latch #(.WIDTH(W)) uut (
      .rst_n(rst_n), .sel_bank(sel_bank),
      .le_a2b1(le_a2b1), .le_a2b2(le_a2b2), .le_b1a(le_b1a), .le_b2a(le_b2a),
      .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n), .oe_b2_n(oe_b2_n),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b1_in(b1_in), .b1_out(b1_out), .b1_oe(b1_oe),
      .b2_in(b2_in), .b2_out(b2_out), .b2_oe(b2_oe)
   );

   function automatic logic [W-1:0] pat(input int i, input int salt);
      int v;
      v = (i * 1447 + salt * 2671) ^ (i << 5) ^ (i >> 2);
      return v[W-1:0];
   endfunction

   task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic step;
      @(negedge clk);
      #5;
   endtask

   initial begin
      rst_n = 1'b0; sel_bank = 1'b0;
      le_a2b1 = 1'b1; le_a2b2 = 1'b1; le_b1a = 1'b1; le_b2a = 1'b1;
      oe_a_n = 1'b0; oe_b1_n = 1'b0; oe_b2_n = 1'b0;
      a_in = 12'hABC; b1_in = 12'h123; b2_in = 12'h456;
      m_d1 = '0; m_d2 = '0; m_u1 = '0; m_u2 = '0;
      step;
      // R1: clear dominates open latches
      chk("R1 b1 under clear", b1_out, '0);
      chk("R1 b2 under clear", b2_out, '0);
      chk("R1 a under clear", a_out, '0);
      sel_bank = 1'b1; step;
      chk("R1 a bank2 under clear", a_out, '0);
      le_a2b1 = 1'b0; le_a2b2 = 1'b0; le_b1a = 1'b0; le_b2a = 1'b0;
      step;
      rst_n = 1'b1; step;
      chk("R1 b1 after clear", b1_out, '0);
      chk("R1 b2 after clear", b2_out, '0);
      chk("R1 a after clear", a_out, '0);

      // R6: each enable alone, all eight combinations
      for (int k = 0; k < 8; k++) begin
         {oe_a_n, oe_b2_n, oe_b1_n} = k[2:0];
         step;
         chk("R6 enables", {9'd0, a_oe, b2_oe, b1_oe}, {9'd0, ~k[2:0]});
      end
      oe_a_n = 1'b0; oe_b1_n = 1'b0; oe_b2_n = 1'b0;

      // R2: bank 1 transparent, bank 2 closed (R8)
      le_a2b1 = 1'b1;
      for (int i = 0; i < 64; i++) begin
         a_in = pat(i, 1); m_d1 = a_in; step;
         chk("R2 bank1 follows A", b1_out, m_d1);
         chk("R8 bank2 untouched", b2_out, m_d2);
      end
      // R3: capture bank 1
      a_in = 12'h5A5; m_d1 = 12'h5A5; step;
      le_a2b1 = 1'b0; step;
      for (int i = 0; i < 16; i++) begin
         a_in = pat(i, 2); step;
         chk("R3 bank1 holds", b1_out, m_d1);
      end
      // R2/R3 bank 2, bank 1 must keep its value (R8)
      le_a2b2 = 1'b1;
      for (int i = 0; i < 64; i++) begin
         a_in = pat(i, 3); m_d2 = a_in; step;
         chk("R2 bank2 follows A", b2_out, m_d2);
         chk("R8 bank1 untouched", b1_out, m_d1);
      end
      a_in = 12'h3C3; m_d2 = 12'h3C3; step;
      le_a2b2 = 1'b0; step;
      for (int i = 0; i < 16; i++) begin
         a_in = pat(i, 4); step;
         chk("R3 bank2 holds", b2_out, m_d2);
      end
      // Both banks open together
      le_a2b1 = 1'b1; le_a2b2 = 1'b1;
      a_in = 12'hF0F; m_d1 = 12'hF0F; m_d2 = 12'hF0F; step;
      chk("R2 both banks b1", b1_out, m_d1);
      chk("R2 both banks b2", b2_out, m_d2);
      le_a2b1 = 1'b0; le_a2b2 = 1'b0; step;

      // R4/R5: bank 1 upward latch
      sel_bank = 1'b0; le_b1a = 1'b1;
      for (int i = 0; i < 64; i++) begin
         b1_in = pat(i, 5); m_u1 = b1_in; step;
         chk("R4 up1 follows", a_out, m_u1);
      end
      b1_in = 12'h0E7; m_u1 = 12'h0E7; step;
      le_b1a = 1'b0; step;
      for (int i = 0; i < 16; i++) begin
         b1_in = pat(i, 6); b2_in = pat(i, 7); step;
         chk("R4 up1 holds", a_out, m_u1);
      end
      sel_bank = 1'b1; step;
      chk("R5 sel=1 shows empty bank2", a_out, m_u2);
      le_b2a = 1'b1;
      for (int i = 0; i < 64; i++) begin
         b2_in = pat(i, 8); m_u2 = b2_in; step;
         chk("R4 up2 follows", a_out, m_u2);
      end
      b2_in = 12'h9D1; m_u2 = 12'h9D1; step;
      le_b2a = 1'b0; step;
      for (int i = 0; i < 16; i++) begin
         b2_in = pat(i, 9); step;
         chk("R4 up2 holds", a_out, m_u2);
      end
      sel_bank = 1'b0; step;
      chk("R5 sel=0 bank1", a_out, m_u1);
      sel_bank = 1'b1; step;
      chk("R5 sel=1 bank2", a_out, m_u2);
      chk("R8 down1 kept", b1_out, m_d1);
      chk("R8 down2 kept", b2_out, m_d2);

      // R9/R7: disable, change inputs with latches closed, re-enable
      oe_a_n = 1'b1; oe_b1_n = 1'b1; oe_b2_n = 1'b1;
      a_in = 12'h111; b1_in = 12'h222; b2_in = 12'h333; step;
      chk("R9 a idle zero", a_out, '0);
      chk("R9 b1 idle zero", b1_out, '0);
      chk("R9 b2 idle zero", b2_out, '0);
      oe_b1_n = 1'b0; step;
      chk("R7 b1 restored", b1_out, m_d1);
      chk("R9 b2 still idle", b2_out, '0);
      oe_b1_n = 1'b1; oe_b2_n = 1'b0; step;
      chk("R7 b2 restored", b2_out, m_d2);
      chk("R9 b1 idle again", b1_out, '0);
      oe_a_n = 1'b0; step;
      chk("R7 a restored bank2", a_out, m_u2);
      sel_bank = 1'b0; step;
      chk("R7 a restored bank1", a_out, m_u1);
      // Loading while disabled still stores (R7 contents independent of enable)
      oe_b1_n = 1'b1; le_a2b1 = 1'b1; a_in = 12'h7E1; m_d1 = 12'h7E1; step;
      le_a2b1 = 1'b0; step;
      oe_b1_n = 1'b0; step;
      chk("R7 load while disabled", b1_out, m_d1);

      // R1: clear again after data
      rst_n = 1'b0; step;
      chk("R1 reclear b1", b1_out, '0);
      chk("R1 reclear a", a_out, '0);
      rst_n = 1'b1; step;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule